// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block guards a running system against stalled software. A counter advances on a tick-enable input and, when it reaches the terminal count chosen by a rate field, the block raises a one-cycle reset request. Software keeps the system alive by writing to a service register, which zeroes the counter and starts a new period. Any data value counts as a service write.

An optional window mode tightens the rule. In this mode a service write is accepted only once the counter has passed three quarters of the terminal count. A service write that comes earlier is itself treated as a fault and raises the reset request at once. The control register can be written once after reset, so code that has gone astray cannot switch the protection off. Two sticky flags record which kind of fault caused the last reset request. A read strobe returns them and clears them.

The counter is a tick counter, so the block does not depend on the clock source. The rate field can stretch the period over several orders of magnitude, and the window always scales with the period that is selected.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `rst_req` is 0, `status` is 0, the rate field is 0 and the control register is unlocked.
- R2: The terminal count for a nonzero rate r is T = 2^E, with E = BASE_EXP + floor((r-1)*(MAX_EXP-BASE_EXP)/(2^RATE_W-2)). The defaults give E from 14 to 24. If T ticks pass after a restart with no accepted service, `rst_req` pulses and the counter restarts from 0. A restart is a control write, a service write or a reset request.
- R3: `rst_req` is high for exactly one clock cycle per fault. It rises on the cycle after the edge at which the fault is detected.
- R4: With the window bit clear, a service write (`wr_addr` = 1) at any count restarts the period. The next timeout is then due T ticks after that write.
- R5: With the window bit set, a service write made while the count is at least T - T/4 is accepted and restarts the period. The boundary count 3T/4 is accepted.
- R6: With the window bit set, a service write made while the count is below T - T/4 raises `rst_req` on the next cycle and sets status bit 1. It also restarts the counter.
- R7: A control write (`wr_addr` = 0) sets the rate from `wr_data[2:0]` and the window bit from `wr_data[7]`, and restarts the counter. Only the first control write after reset takes effect; any later control write is ignored.
- R8: The counter advances only on edges where `tick_en` is 1. While `tick_en` is 0, no timeout can occur.
- R9: Status bit 0 is set on a timeout and status bit 1 on an early service write. Both stay set until a cycle with `rd_en` = 1, after which they read 0. If a new fault arrives in the same cycle as the read, the new fault wins.
- R10: While the rate is 0, the watchdog is off. No timeout occurs, and service writes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects service |
| wr_data | input | DATA_W | Write data; control uses bits [RATE_W-1:0] and WIN_BIT |
| rd_en | input | 1 | Status read strobe, clears the flags |
| rst_req | output | 1 | One-cycle reset request |
| status | output | 2 | Bit 0 set by timeout, bit 1 set by early service |

## Verification
A write or read strobe presented before edge N takes effect at edge N. A fault found at edge N shows on `rst_req` and `status` from edge N until edge N+1. For that reason the bench samples at the falling edge that follows. A timeout is due exactly T ticking edges after the restarting edge. An early service write shows its pulse at the very edge that captured it, and a status read shows zero flags at the falling edge right after the read edge. The driver records the edge number at which each pulse is due, together with its cause. The monitor compares every pulse with that record, so a pulse that comes early, late, twice or without cause is reported.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_SVC  = 1'b1
   } wwdt_sel_e;

   // Period exponent for a rate code; code 0 means the watchdog is off.
   function automatic int unsigned exp_for(input int unsigned rate,
                                           input int unsigned base,
                                           input int unsigned top,
                                           input int unsigned rate_w);
      int unsigned steps;
      steps = (32'd1 << rate_w) - 32'd2;
      if (rate == 0) return 0;
      return base + ((rate - 1) * (top - base)) / steps;
   endfunction

endpackage

// File: rtl/wwdt_cfg.sv
module wwdt_cfg #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned RATE_W  = 3,
   parameter int unsigned WIN_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [RATE_W-1:0] rate_q,
   output logic              win_q,
   output logic              locked_q,
   output logic              restart
);

   // only the first control write after reset is taken
   assign restart = ctrl_wr && !locked_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q   <= '0;
         win_q    <= 1'b0;
         locked_q <= 1'b0;
      end else if (restart) begin
         rate_q   <= wr_data[RATE_W-1:0];
         win_q    <= wr_data[WIN_BIT];
         locked_q <= 1'b1;
      end
   end

endmodule

// File: rtl/wwdt_count.sv
module wwdt_count
   import wwdt_pkg::*;
#(
   parameter int unsigned RATE_W     = 3,
   parameter int unsigned BASE_EXP   = 14,
   parameter int unsigned MAX_EXP    = 24,
   parameter bit          HAS_WINDOW = 1'b1,
   localparam int unsigned CNT_W     = MAX_EXP,
   localparam int unsigned TERM_W    = MAX_EXP + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              svc_wr,
   input  logic              restart,
   input  logic [RATE_W-1:0] rate,
   input  logic              win,
   output logic [CNT_W-1:0]  cnt,
   output logic [TERM_W-1:0] thresh,
   output logic              timeout_ev,
   output logic              early_ev
);

   localparam int unsigned NRATE = 1 << RATE_W;

   logic [TERM_W-1:0] term_tab [NRATE];
   logic [TERM_W-1:0] term;
   logic [TERM_W-1:0] cnt_ext;
   logic              enabled;
   logic              win_eff;
   logic              last;
   logic              svc_ok;

   // terminal count per rate code
   for (genvar k = 0; k < NRATE; k++) begin : g_term
      localparam int unsigned E = exp_for(k, BASE_EXP, MAX_EXP, RATE_W);
      if (k == 0) begin : g_off
         assign term_tab[k] = '0;
      end else begin : g_on
         assign term_tab[k] = TERM_W'(1) << E;
      end
   end

   if (HAS_WINDOW) begin : g_win
      assign win_eff = win;
   end else begin : g_nowin
      assign win_eff = 1'b0;
      logic unused_win;
      assign unused_win = win;
   end

   assign enabled = (rate != '0);
   assign term    = term_tab[rate];
   assign thresh  = term - (term >> 2);
   assign cnt_ext = {1'b0, cnt};
   assign last    = (cnt_ext == term - TERM_W'(1));

   assign svc_ok     = svc_wr && enabled && (!win_eff || cnt_ext >= thresh);
   assign early_ev   = svc_wr && enabled && win_eff && (cnt_ext < thresh);
   assign timeout_ev = enabled && tick_en && last && !svc_ok && !early_ev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || !enabled || svc_ok || early_ev) begin
         cnt <= '0;
      end else if (tick_en) begin
         cnt <= last ? '0 : CNT_W'(cnt + 1'b1);
      end
   end

endmodule

// File: rtl/wwdt_flags.sv
module wwdt_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       timeout_ev,
   input  logic       early_ev,
   input  logic       rd_en,
   output logic       rst_req,
   output logic [1:0] status
);

   logic [1:0] hits;

   assign hits = {early_ev, timeout_ev};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         status  <= 2'b00;
      end else begin
         rst_req <= timeout_ev | early_ev;
         status  <= hits | (rd_en ? 2'b00 : status);
      end
   end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
   import wwdt_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned RATE_W     = 3,
   parameter int unsigned WIN_BIT    = 7,
   parameter int unsigned BASE_EXP   = 14,
   parameter int unsigned MAX_EXP    = 24,
   parameter bit          HAS_WINDOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic              rst_req,
   output logic [1:0]        status
);

   localparam int unsigned CNT_W  = MAX_EXP;
   localparam int unsigned TERM_W = MAX_EXP + 1;

   if (RATE_W < 2 || MAX_EXP < BASE_EXP || BASE_EXP < 2) begin : g_bad_period
      $error("win_watchdog: invalid period parameters");
   end
   if (WIN_BIT >= DATA_W || RATE_W > WIN_BIT) begin : g_bad_field
      $error("win_watchdog: control fields do not fit the data width");
   end

   logic [RATE_W-1:0] rate_q;
   logic              win_q;
   logic              locked_q;
   logic              restart;
   logic [CNT_W-1:0]  cnt;
   logic [TERM_W-1:0] thresh;
   logic              timeout_ev;
   logic              early_ev;
   logic              ctrl_wr;
   logic              svc_wr;

   assign ctrl_wr = wr_en && (wwdt_sel_e'(wr_addr) == SEL_CTRL);
   assign svc_wr  = wr_en && (wwdt_sel_e'(wr_addr) == SEL_SVC);

   wwdt_cfg #(
      .DATA_W (DATA_W),
      .RATE_W (RATE_W),
      .WIN_BIT(WIN_BIT)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (ctrl_wr),
      .wr_data (wr_data),
      .rate_q  (rate_q),
      .win_q   (win_q),
      .locked_q(locked_q),
      .restart (restart)
   );

   wwdt_count #(
      .RATE_W    (RATE_W),
      .BASE_EXP  (BASE_EXP),
      .MAX_EXP   (MAX_EXP),
      .HAS_WINDOW(HAS_WINDOW)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .svc_wr    (svc_wr),
      .restart   (restart),
      .rate      (rate_q),
      .win       (win_q),
      .cnt       (cnt),
      .thresh    (thresh),
      .timeout_ev(timeout_ev),
      .early_ev  (early_ev)
   );

   wwdt_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .timeout_ev(timeout_ev),
      .early_ev  (early_ev),
      .rd_en     (rd_en),
      .rst_req   (rst_req),
      .status    (status)
   );

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
   parameter int unsigned RATE_W = 3,
   parameter int unsigned CNT_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              wr_en,
   input logic              wr_addr,
   input logic              rd_en,
   input logic              rst_req,
   input logic [1:0]        status,
   input logic [RATE_W-1:0] rate_q,
   input logic              win_q,
   input logic              locked_q,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W:0]    thresh
);

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req && !wr_en |=> !rst_req);

   a_r5_window_accept: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr && (rate_q != '0) && ({1'b0, cnt} >= thresh)
      |=> !rst_req && (cnt == '0));

   a_r6_early_reset: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr && (rate_q != '0) && win_q && ({1'b0, cnt} < thresh)
      |=> rst_req && status[1]);

   a_r7_write_once: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q && $stable(rate_q) && $stable(win_q));

   a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en && !wr_en |=> $stable(cnt));

   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !tick_en && !wr_en |=> status == 2'b00);

   a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rate_q == '0 |=> !rst_req);

endmodule

bind win_watchdog win_watchdog_chk #(
   .RATE_W(RATE_W),
   .CNT_W (MAX_EXP)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_en (tick_en),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .rd_en   (rd_en),
   .rst_req (rst_req),
   .status  (status),
   .rate_q  (rate_q),
   .win_q   (win_q),
   .locked_q(locked_q),
   .cnt     (cnt),
   .thresh  (thresh)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;

   localparam int unsigned BASE_EXP = 4;
   localparam int unsigned MAX_EXP  = 10;
   // expected periods from R2 with these parameters
   localparam int T1 = 16;    // rate 1, exponent 4
   localparam int T2 = 32;    // rate 2, exponent 5
   localparam int T7 = 1024;  // rate 7, exponent 10

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic       rst_req;
   logic [1:0] status;

   int edge_n = 0;
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int exp_edge[$];
   bit exp_early[$];

   always #5 clk = ~clk;
   always @(posedge clk) edge_n <= edge_n + 1;

   win_watchdog #(
      .BASE_EXP(BASE_EXP),
      .MAX_EXP (MAX_EXP)
   ) uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_en(tick_en),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_en  (rd_en),
      .rst_req(rst_req),
      .status (status)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // monitor: each reset request pulse is compared with the scoreboard
   always @(negedge clk) begin
      if (rst_n && rst_req) begin
         if (exp_edge.size() == 0) begin
            check(1'b0, "R3/R10 unexpected pulse", edge_n, -1);
         end else begin
            int  e;
            bit  early;
            e     = exp_edge.pop_front();
            early = exp_early.pop_front();
            check(edge_n == e, early ? "R6 pulse edge" : "R2 pulse edge", edge_n, e);
            check(status[early] == 1'b1, early ? "R9 early flag" : "R9 timeout flag",
                  status[early], 1);
         end
      end
   end

   task automatic push(input int e, input bit early);
      exp_edge.push_back(e);
      exp_early.push_back(early);
   endtask

   task automatic wait_empty();
      while (exp_edge.size() != 0) begin
         @(negedge clk);
         #1;
      end
   endtask

   // drive a write that is captured at edge number tgt
   task automatic write_at(input int tgt, input bit addr, input logic [7:0] data);
      while (edge_n < tgt - 1) @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic write_now(input bit addr, input logic [7:0] data, output int at);
      at = edge_n + 1;
      write_at(at, addr, data);
   endtask

   task automatic read_status(input int expv, input string req);
      check(status == expv[1:0], req, status, expv);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(status == 2'b00, "R9 cleared after read", status, 0);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      exp_edge.delete();
      exp_early.delete();
      tick_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int w, s, p;
      // ---- R1 / R10: reset state and disabled watchdog
      do_reset();
      check(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);
      check(status == 2'b00, "R1 status after reset", status, 0);
      repeat (100) @(negedge clk);
      write_now(1'b1, 8'h00, s);      // R10 service while off: no effect
      repeat (200) @(negedge clk);
      check(status == 2'b00, "R10 no fault while off", status, 0);

      // ---- R2 / R4 / R7 / R8 / R9: rate 2, window off
      write_now(1'b0, 8'h02, w);
      push(w + T2, 1'b0);
      wait_empty();
      p = w + T2;
      write_now(1'b1, 8'h5A, s);      // R4 service right after restart
      push(s + T2, 1'b0);
      wait_empty();
      p = s + T2;
      read_status(1, "R9 timeout flag held");
      write_now(1'b0, 8'h87, s);      // R7 second control write ignored
      push(p + T2, 1'b0);
      wait_empty();
      p = p + T2;
      tick_en = 1'b0;                 // R8 ticks stopped for 40 edges
      repeat (40) @(negedge clk);
      tick_en = 1'b1;
      push(p + 40 + T2, 1'b0);
      wait_empty();

      // ---- R5 / R6: rate 1, window on, threshold 12
      do_reset();
      write_now(1'b0, 8'h81, w);
      write_at(w + 14, 1'b1, 8'h00);  // count 13: accepted (R5)
      s = w + 14 + 5;                 // count 4: early (R6)
      push(s, 1'b1);
      write_at(s, 1'b1, 8'h00);
      wait_empty();
      write_at(s + 13, 1'b1, 8'h00);  // count 12, boundary accepted (R5)
      p = s + 13 + 12;                // count 11: early (R6)
      push(p, 1'b1);
      write_at(p, 1'b1, 8'h00);
      wait_empty();
      push(p + T1, 1'b0);             // no further service: timeout (R2)
      wait_empty();
      read_status(3, "R9 both flags held");

      // ---- R2: largest rate
      do_reset();
      write_now(1'b0, 8'h07, w);
      push(w + T7, 1'b0);
      wait_empty();
      repeat (5) @(negedge clk);
      check(exp_edge.size() == 0, "R3 no extra pulse", exp_edge.size(), 0);

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule